// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of audio words into a serial audio frame made of a bit clock, a frame sync and a data line. Words are written into a small internal FIFO. The block raises a data request while the FIFO is at or below half full. At the start of every word slot it takes one word from the FIFO and shifts it out MSB first, one bit per bit clock. The data line changes only on falling bit-clock edges, so a receiver samples it on rising edges.

All timing is run-time configuration held on input ports: master or slave operation, the bit-clock divider, the number of words per frame, the word width, the sync pulse width, whether the sync leads the frame by one bit, and the sync polarity. The usual stereo setting is a divider of 3, two 16-bit words and a 16-bit-wide active-low sync that leads by one bit. With that setting the frame is 32 bit clocks, and the master clock runs at 8 times the bit rate. In master mode the block generates the bit clock and the sync from the master clock. In slave mode both arrive on inputs, and the block follows the sync edge to align its frame.

When a word slot starts with an empty FIFO, the block sends zeros for that slot and sets a sticky underrun flag. A pulse on the clear input resets the flag.

Top module: `i2s_tx`

## Requirements
- R1: In master mode with `en` high, `bclk_o` starts low and toggles after every `cfg_div`+1 clock cycles. Its first rise comes `cfg_div`+1 cycles after `en` goes high. `bclk_o` is low whenever `en` is low.
- R2: `sdata_o` changes only in the cycle that follows a falling bit-clock edge. Each word goes out MSB first, starting at bit `cfg_wlen` and ending at bit 0, with one bit per bit-clock period.
- R3: A frame holds `cfg_words`+1 word slots of `cfg_wlen`+1 bits each. Each slot takes the next FIFO word, in the order the words were written.
- R4: In master mode the sync is asserted for `cfg_syncw`+1 bit periods. With `cfg_early`=0 it starts on bit 0 of word 0. With `cfg_early`=1 it starts one bit earlier, on the last bit of the previous frame.
- R5: With `cfg_fs_low`=1 the asserted sync level on `fs_o` is 0, and with `cfg_fs_low`=0 it is 1. While the sync is deasserted or the block is disabled, `fs_o` shows the opposite level.
- R6: `dreq` is high exactly while FIFO occupancy is at or below DEPTH/2. After reset `dreq` is high.
- R7: A write with `wr_en` high while the FIFO holds DEPTH words is dropped, and that word is never transmitted.
- R8: If the FIFO is empty at the start of a word slot, that slot sends all zeros and `underrun` goes high. It stays high until cleared.
- R9: `err_clr`=1 clears `underrun` on the next edge. If a new underrun happens in the same cycle, the set wins.
- R10: In slave mode `bclk_o` is held low and `fs_o` is held at the deasserted level. Bit timing follows falling edges of `bclk_in`. When a newly asserted `fs_in` is seen at a rising edge of `bclk_in` and the frame is out of step, the next bit becomes bit 0 of word 0 if `cfg_early`=1, or bit 1 of word 0 if `cfg_early`=0. In that case a fresh word is loaded.
- R11: While `en` is low, `sdata_o` is 0 and the frame position returns to bit 0 of word 0. FIFO contents and `underrun` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable |
| cfg_master | input | 1 | 1: generate the bit clock and sync; 0: follow the inputs |
| cfg_div | input | DIV_W | Bit-clock half-period in master clocks, minus one |
| cfg_words | input | clog2(MAX_WORDS) | Word slots per frame, minus one |
| cfg_wlen | input | clog2(WORD_W) | Bits per word, minus one (at least 1) |
| cfg_syncw | input | clog2(WORD_W*MAX_WORDS) | Sync width in bit periods, minus one |
| cfg_early | input | 1 | Sync leads the frame by one bit |
| cfg_fs_low | input | 1 | Sync asserted level is low |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | WORD_W | Word to queue, right-aligned |
| dreq | output | 1 | FIFO at or below its watermark |
| bclk_in | input | 1 | Bit clock in slave mode |
| fs_in | input | 1 | Frame sync in slave mode |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Generated frame sync |
| sdata_o | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |
| err_clr | input | 1 | Clears `underrun` |

## Verification
A wrong divider count or a lost bit-clock phase shows up on `bclk_o` within one half period. A frame counter that is off by one moves the sync window, and `fs_o` shows this at the next frame boundary, which is at most one frame later. A bad FIFO pointer or occupancy count shows up on `dreq` in the next cycle, and as a wrong or repeated word on `sdata_o` at the next word slot. A behavioural model in the bench tracks every port on every cycle. Any divergence is therefore caught at the first bit where it becomes visible.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int unsigned DEF_WORD_W    = 32;
  localparam int unsigned DEF_MAX_WORDS = 8;
  localparam int unsigned DEF_DEPTH     = 8;
  localparam int unsigned DEF_DIV_W     = 8;

  // Is the bit about to go out inside the sync window?
  // pos: bit index within the frame; at_end: pos is the frame's last bit.
  function automatic logic sync_window(input logic early, input logic at_end,
                                       input int unsigned pos,
                                       input int unsigned width_m1);
    if (early) return at_end || (pos < width_m1);
    return pos <= width_m1;
  endfunction

endpackage

// File: rtl/i2s_bitclk.sv
module i2s_bitclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             bclk_in,
  output logic             bclk_o,
  output logic             fall,
  output logic             slv_rise
);

  logic [DIV_W-1:0] cnt;
  logic             bclk_r;
  logic             bq;
  logic             mst_on;
  logic             slv_on;
  logic             term;

  assign mst_on = en & master;
  assign slv_on = en & ~master;
  assign term   = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bclk_r <= 1'b0;
      bq     <= 1'b0;
    end else begin
      bq <= bclk_in;
      if (!mst_on) begin
        cnt    <= '0;
        bclk_r <= 1'b0;
      end else if (term) begin
        cnt    <= '0;
        bclk_r <= ~bclk_r;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (mst_on) fall = term & bclk_r;
    else        fall = slv_on & bq & ~bclk_in;
    slv_rise = slv_on & ~bq & bclk_in;
  end

  assign bclk_o = bclk_r;

  assert_bclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !master |=> !bclk_o);

  assert_bclk_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (mst_on && !term) |=> $stable(bclk_o));

  assert_fall_from_high_R2: assert property (@(posedge clk) disable iff (rst)
    (fall && master) |-> bclk_o);

endmodule

// File: rtl/i2s_word_fifo.sv
module i2s_word_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WMARK  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              dreq
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;
  logic [CW-1:0]     count;
  logic [CW-1:0]     count_nxt;
  logic              full;
  logic              push;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_en & ~full;
  assign head  = mem[rptr];

  always_comb begin
    case ({push, pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dreq  <= 1'b1;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      count <= count_nxt;
      dreq  <= (count_nxt <= CW'(WMARK));
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> $stable(count));

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);

endmodule

// File: rtl/i2s_framer.sv
module i2s_framer
  import i2s_tx_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 8,
  parameter int unsigned LW        = $clog2(WORD_W),
  parameter int unsigned WIW       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  parameter int unsigned FPW       = $clog2(WORD_W * MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              master,
  input  logic [LW-1:0]     wlen,
  input  logic [WIW-1:0]    words,
  input  logic [FPW-1:0]    syncw,
  input  logic              early,
  input  logic              fs_low,
  input  logic              fall,
  input  logic              slv_rise,
  input  logic              fs_in,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  input  logic              err_clr,
  output logic              pop,
  output logic              sdata,
  output logic              fs_act,
  output logic              underrun
);

  logic [LW-1:0]     bi;
  logic [WIW-1:0]    wi;
  logic [FPW-1:0]    fp;
  logic [WORD_W-1:0] cur;
  logic              fs_smp;
  logic              fs_prv;

  logic [LW-1:0]     tgt;
  logic              realign;
  logic [LW-1:0]     p_bi;
  logic [WIW-1:0]    p_wi;
  logic [FPW-1:0]    p_fp;
  logic              load;
  logic [WORD_W-1:0] src;
  logic              bit_now;
  logic              word_end;
  logic              frame_end;
  logic              sync_now;
  logic              und_set;

  always_comb begin
    tgt       = early ? '0 : LW'(1);
    realign   = ~master & fs_smp & ~fs_prv & (fp != FPW'(tgt));
    p_bi      = realign ? tgt : bi;
    p_wi      = realign ? '0 : wi;
    p_fp      = realign ? FPW'(tgt) : fp;
    load      = realign | (p_bi == '0);
    if (load) src = empty ? '0 : head;
    else      src = cur;
    bit_now   = src[wlen - p_bi];
    word_end  = (p_bi == wlen);
    frame_end = word_end & (p_wi == words);
    sync_now  = master & sync_window(early, frame_end, 32'(p_fp), 32'(syncw));
    pop       = en & fall & load & ~empty;
    und_set   = en & fall & load & empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bi     <= '0;
      wi     <= '0;
      fp     <= '0;
      cur    <= '0;
      sdata  <= 1'b0;
      fs_act <= 1'b0;
    end else if (!en) begin
      bi     <= '0;
      wi     <= '0;
      fp     <= '0;
      cur    <= '0;
      sdata  <= 1'b0;
      fs_act <= 1'b0;
    end else if (fall) begin
      cur    <= src;
      sdata  <= bit_now;
      fs_act <= sync_now;
      if (word_end) begin
        bi <= '0;
        wi <= frame_end ? '0 : p_wi + 1'b1;
      end else begin
        bi <= p_bi + 1'b1;
        wi <= p_wi;
      end
      fp <= frame_end ? '0 : p_fp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || master) begin
      fs_smp <= 1'b0;
      fs_prv <= 1'b0;
    end else if (slv_rise) begin
      fs_prv <= fs_smp;
      fs_smp <= fs_in ^ fs_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          underrun <= 1'b0;
    else if (und_set) underrun <= 1'b1;
    else if (err_clr) underrun <= 1'b0;
  end

  assert_sdata_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (sdata != $past(sdata)) |-> $past(fall || !en));

  assert_und_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (underrun && !err_clr) |=> underrun);

  assert_slave_nosync_R10: assert property (@(posedge clk) disable iff (rst)
    (!master && fall) |=> !fs_act);

  assert_idle_data_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sdata);

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned MAX_WORDS = DEF_MAX_WORDS,
  parameter int unsigned DEPTH     = DEF_DEPTH,
  parameter int unsigned DIV_W     = DEF_DIV_W,
  localparam int unsigned LW       = $clog2(WORD_W),
  localparam int unsigned WIW      = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int unsigned FPW      = $clog2(WORD_W * MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WIW-1:0]    cfg_words,
  input  logic [LW-1:0]     cfg_wlen,
  input  logic [FPW-1:0]    cfg_syncw,
  input  logic              cfg_early,
  input  logic              cfg_fs_low,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dreq,
  input  logic              bclk_in,
  input  logic              fs_in,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              sdata_o,
  output logic              underrun,
  input  logic              err_clr
);

  logic              fall;
  logic              slv_rise;
  logic              pop;
  logic              empty;
  logic [WORD_W-1:0] head;
  logic              fs_act;

  i2s_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .master   (cfg_master),
    .div      (cfg_div),
    .bclk_in  (bclk_in),
    .bclk_o   (bclk_o),
    .fall     (fall),
    .slv_rise (slv_rise)
  );

  i2s_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .WMARK(DEPTH / 2)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pop     (pop),
    .head    (head),
    .empty   (empty),
    .dreq    (dreq)
  );

  i2s_framer #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .LW(LW), .WIW(WIW), .FPW(FPW)
  ) u_frm (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .master   (cfg_master),
    .wlen     (cfg_wlen),
    .words    (cfg_words),
    .syncw    (cfg_syncw),
    .early    (cfg_early),
    .fs_low   (cfg_fs_low),
    .fall     (fall),
    .slv_rise (slv_rise),
    .fs_in    (fs_in),
    .empty    (empty),
    .head     (head),
    .err_clr  (err_clr),
    .pop      (pop),
    .sdata    (sdata_o),
    .fs_act   (fs_act),
    .underrun (underrun)
  );

  // Polarity is applied after the registered sync state.
  assign fs_o = fs_act ^ cfg_fs_low;

endmodule

// File: tb/i2s_tx_test.sv
module i2s_tx_test;

  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic        cfg_master;
  logic [7:0]  cfg_div;
  logic [2:0]  cfg_words;
  logic [4:0]  cfg_wlen;
  logic [7:0]  cfg_syncw;
  logic        cfg_early;
  logic        cfg_fs_low;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        dreq;
  logic        bclk_in;
  logic        fs_in;
  logic        bclk_o;
  logic        fs_o;
  logic        sdata_o;
  logic        underrun;
  logic        err_clr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int seq = 0;

  i2s_tx uut (
    .clk(clk), .rst(rst), .en(en), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .cfg_words(cfg_words), .cfg_wlen(cfg_wlen), .cfg_syncw(cfg_syncw),
    .cfg_early(cfg_early), .cfg_fs_low(cfg_fs_low), .wr_en(wr_en),
    .wr_data(wr_data), .dreq(dreq), .bclk_in(bclk_in), .fs_in(fs_in),
    .bclk_o(bclk_o), .fs_o(fs_o), .sdata_o(sdata_o), .underrun(underrun),
    .err_clr(err_clr)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          md, mfp;
  bit          mb, mbq, fsm, fsp, msd, mfs, merr, mdreq;
  logic [31:0] mcur;
  logic [31:0] mq[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      md = 0; mb = 0; mbq = 0; fsm = 0; fsp = 0; mfp = 0; mcur = 0;
      msd = 0; mfs = 0; merr = 0; mdreq = 1; mq.delete();
    end else begin
      int W, L, pos, bi, tgt;
      bit full, empty, fall, sfall, srise, load, set;
      W = int'(cfg_wlen) + 1;
      L = (int'(cfg_words) + 1) * W;
      full = (mq.size() == DEPTH);
      empty = (mq.size() == 0);
      fall = 0;
      set = 0;
      if (en && cfg_master) begin
        if (md == int'(cfg_div)) begin
          md = 0;
          if (mb) fall = 1;
          mb = !mb;
        end else md++;
      end else begin
        md = 0; mb = 0;
      end
      sfall = en && !cfg_master && mbq && !bclk_in;
      srise = en && !cfg_master && !mbq && bclk_in;
      mbq = bclk_in;
      if (!en) begin
        mfp = 0; mcur = 0; msd = 0; mfs = 0;
      end else if (fall || sfall) begin
        tgt = cfg_early ? 0 : 1;
        pos = mfp;
        load = 0;
        if (!cfg_master && fsm && !fsp && mfp != tgt) begin
          pos = tgt; load = 1;
        end
        bi = pos % W;
        if (bi == 0) load = 1;
        if (load) begin
          if (empty) begin mcur = 0; set = 1; end
          else mcur = mq.pop_front();
        end
        msd = mcur[int'(cfg_wlen) - bi];
        if (cfg_early) mfs = cfg_master && (pos == L - 1 || pos < int'(cfg_syncw));
        else           mfs = cfg_master && (pos <= int'(cfg_syncw));
        mfp = (pos == L - 1) ? 0 : pos + 1;
      end
      if (!(en && !cfg_master)) begin
        fsm = 0; fsp = 0;
      end else if (srise) begin
        fsp = fsm; fsm = fs_in ^ cfg_fs_low;
      end
      if (set) merr = 1;
      else if (err_clr) merr = 0;
      if (wr_en && !full) mq.push_back(wr_data);
      mdreq = (mq.size() <= DEPTH / 2);
    end
  end

  // Compare every port against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!en) begin
        chk("R11 sdata idle", 32'(sdata_o), 32'(msd));
        chk("R1 R11 bclk idle", 32'(bclk_o), 32'(mb));
      end
      if (cfg_master) begin
        chk("R1 bclk", 32'(bclk_o), 32'(mb));
        chk("R2 R3 R7 sdata", 32'(sdata_o), 32'(msd));
        chk("R4 R5 fs", 32'(fs_o), 32'(mfs ^ cfg_fs_low));
      end else begin
        chk("R10 bclk held", 32'(bclk_o), 32'(mb));
        chk("R10 sdata", 32'(sdata_o), 32'(msd));
        chk("R10 R5 fs idle", 32'(fs_o), 32'(mfs ^ cfg_fs_low));
      end
      chk("R6 dreq", 32'(dreq), 32'(mdreq));
      chk("R8 R9 underrun", 32'(underrun), 32'(merr));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mkword(input int n);
    return (32'(n) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic run_fed(input int n, input bit feed);
    for (int i = 0; i < n; i++) begin
      wr_en = feed && dreq;
      wr_data = mkword(seq);
      if (feed && dreq) seq++;
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  // Slave stimulus: bclk_in with a half period of hp cycles; the sync is
  // active low and leads by one bit for a 32-bit frame.
  task automatic run_slave(input int bits, input int start, input int hp);
    int k;
    k = start;
    for (int b = 0; b < bits; b++) begin
      bclk_in = 0;
      fs_in = (k == 31 || k < 15) ? 1'b0 : 1'b1;
      for (int h = 0; h < hp; h++) begin
        wr_en = dreq; wr_data = mkword(seq); if (dreq) seq++;
        @(negedge clk);
      end
      bclk_in = 1;
      for (int h = 0; h < hp; h++) begin
        wr_en = dreq; wr_data = mkword(seq); if (dreq) seq++;
        @(negedge clk);
      end
      k = (k + 1) % 32;
    end
    wr_en = 0;
  endtask

  initial begin
    rst = 1; en = 0; cfg_master = 1; cfg_div = 8'd3; cfg_words = 3'd1;
    cfg_wlen = 5'd15; cfg_syncw = 8'd15; cfg_early = 1; cfg_fs_low = 1;
    wr_en = 0; wr_data = 0; bclk_in = 0; fs_in = 1; err_clr = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset bclk", 32'(bclk_o), 32'd0);
    chk("R11 reset sdata", 32'(sdata_o), 32'd0);
    chk("R6 reset dreq", 32'(dreq), 32'd1);
    chk("R8 reset underrun", 32'(underrun), 32'd0);
    chk("R5 reset fs idle", 32'(fs_o), 32'd1);
    rst = 0;
    @(negedge clk);

    // Overfill while disabled: the ninth word must be dropped.
    for (int i = 0; i < 9; i++) begin
      wr_en = 1; wr_data = mkword(seq); seq++;
      @(negedge clk);
    end
    wr_en = 0;
    @(negedge clk);
    chk("R6 R7 dreq low when full", 32'(dreq), 32'd0);

    // Standard stereo frame in master mode.
    en = 1;
    repeat (3) @(negedge clk);
    chk("R1 no rise before div+1", 32'(bclk_o), 32'd0);
    @(negedge clk);
    chk("R1 first rise at div+1", 32'(bclk_o), 32'd1);
    run_fed(3000, 1);

    // Starve the FIFO.
    run_fed(900, 0);
    chk("R8 underrun raised", 32'(underrun), 32'd1);
    chk("R8 zero data", 32'(sdata_o), 32'd0);
    en = 0;
    repeat (3) @(negedge clk);
    chk("R11 disabled sdata", 32'(sdata_o), 32'd0);
    chk("R8 underrun sticky", 32'(underrun), 32'd1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk("R9 underrun cleared", 32'(underrun), 32'd0);

    // Wider frame, short non-early active-high sync, faster bit clock.
    cfg_div = 8'd1; cfg_words = 3'd3; cfg_wlen = 5'd7; cfg_syncw = 8'd0;
    cfg_early = 0; cfg_fs_low = 0;
    run_fed(6, 1);
    en = 1;
    run_fed(2500, 1);
    en = 0;
    run_fed(4, 0);

    // Non-early, wide sync, 24-bit words.
    cfg_div = 8'd2; cfg_words = 3'd1; cfg_wlen = 5'd23; cfg_syncw = 8'd23;
    cfg_early = 0; cfg_fs_low = 1;
    run_fed(6, 1);
    en = 1;
    run_fed(2500, 1);
    en = 0;
    run_fed(4, 0);

    // Slave mode following external clocks, entered mid-frame.
    cfg_master = 0; cfg_words = 3'd1; cfg_wlen = 5'd15; cfg_syncw = 8'd15;
    cfg_early = 1; cfg_fs_low = 1;
    run_fed(8, 1);
    en = 1;
    run_slave(200, 20, 3);
    chk("R10 bclk_o held low", 32'(bclk_o), 32'd0);
    chk("R10 fs_o held idle", 32'(fs_o), 32'd1);
    en = 0;
    run_fed(4, 0);

    // Slave, non-early timing.
    cfg_early = 0;
    en = 1;
    run_slave(200, 7, 2);
    en = 0;
    run_fed(4, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule